// File: doc/BRIEF.md
# Power-of-Two Sample Decimator Latch

This block sits behind a fast sampling converter. It takes one 8-bit sample per clock when the sample-valid strobe is high. It keeps one valid sample out of every 2^k, where k comes from a 3-bit ratio select, so the ratio runs from 1/1 to 1/128. Each kept sample is held in an output register until the next kept sample arrives.

Next to the held word, the block drives a derived output clock that downstream logic uses to capture the word. It also drives a second copy of the word meant for a monitor DAC. That copy is normally the bitwise complement of the held sample. A polarity input can make it equal to the held sample instead.

A divide counter counts valid samples only. When the ratio select changes, the counter starts again from zero, so a new ratio always begins on a kept sample. A synchronous reset clears every register and drives all outputs to zero.

Top module: `pow2_decim_latch`

## Requirements
- R1: While `rst` is high at a clock edge, `out_data`, `dac_data` and `out_clk` are all zero after that edge. The divide counter is cleared, and the value of `ratio_sel` present during reset is taken as the current ratio.
- R2: `ratio_sel` = k selects a decimation ratio of 1/2^k, for k = 0 to 7 (000 gives 1/1, 111 gives 1/128). A valid sample is kept when the counter is zero. The counter counts valid samples from 0 up to 2^k-1 and then wraps to 0. So the kept samples are the first valid sample after reset or after a ratio change, and then every 2^k-th valid sample.
- R3: At ratio 1/1, every valid sample appears on `out_data` one clock after it is presented.
- R4: Between kept samples, `out_data` holds its value.
- R5: For k > 0, `out_clk` is high for the first 2^(k-1) valid samples of each period, starting with the kept sample, and low for the rest. It is registered in the same edge as the data, and it changes only on a valid sample or on a ratio change.
- R6: At ratio 1/1, `out_clk` equals `smp_vld` delayed by one clock.
- R7: In a cycle where `ratio_sel` differs from the current ratio, no sample is kept, `out_clk` goes low and the counter restarts at zero. The next valid sample is kept.
- R8: `dac_data` is the bitwise complement of `out_data` when `dac_pol` was 0 in the previous cycle, and equal to `out_data` when it was 1.
- R9: A cycle with `smp_vld` low neither advances the counter nor captures a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | A sample is present this cycle |
| smp_data | input | 8 | Converter sample |
| ratio_sel | input | 3 | Decimation ratio select, ratio 1/2^ratio_sel |
| dac_pol | input | 1 | 0: DAC copy is complemented, 1: DAC copy is true |
| out_data | output | 8 | Held decimated sample |
| out_clk | output | 1 | Derived output clock for capturing `out_data` |
| dac_data | output | 8 | Monitor copy of the held sample for the DAC |

## Verification
The bound assertions check these rules on every cycle:
- the all-zero state after reset;
- that the held word stays put when no sample arrives;
- that a ratio change forces the output clock low without capturing;
- that the DAC copy tracks the held word with the polarity from the cycle before;
- that the output clock at 1/1 is a delayed copy of the valid strobe.

Other behaviour depends on counting across a whole period, and only the bench scenarios show it. This includes which sample is kept at each ratio, where the output clock's high half ends, and how gaps in the valid strobe stretch the period. The bench covers this with a cycle-accurate reference model built from the requirements, and compares it with the design over several ratios, valid patterns and polarity changes.

// File: rtl/dec_pkg.sv
package dec_pkg;

    // What the output clock register does this cycle
    typedef enum logic [1:0] {
        OCLK_CLEAR  = 2'd0,   // ratio change: force low
        OCLK_FOLLOW = 2'd1,   // ratio 1/1: copy the valid strobe
        OCLK_PHASE  = 2'd2,   // valid sample at ratio > 1: use phase
        OCLK_HOLD   = 2'd3    // no sample: keep value
    } oclk_act_e;

endpackage

// File: rtl/dec_phase_ctr.sv
module dec_phase_ctr
    import dec_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             keep_o,
    output logic             phase_hi_o,
    output oclk_act_e        oclk_act_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    logic             restart;
    logic [CNT_W-1:0] term_cnt;
    logic [CNT_W-1:0] half_lim;

    always_comb begin
        st_d     = st_q;
        restart  = (sel_i != st_q.sel);
        // Terminal count 2^sel - 1 as a mask of low ones
        term_cnt = ~({CNT_W{1'b1}} << sel_i);
        // First half of the period: cnt below 2^(sel-1)
        half_lim = (sel_i == '0) ? CNT_W'(1)
                                 : (CNT_W'(1) << (sel_i - SEL_W'(1)));

        keep_o     = !restart && vld_i && (st_q.cnt == '0);
        phase_hi_o = (st_q.cnt < half_lim);

        if (restart) begin
            oclk_act_o = OCLK_CLEAR;
        end else if (sel_i == '0) begin
            oclk_act_o = OCLK_FOLLOW;
        end else if (vld_i) begin
            oclk_act_o = OCLK_PHASE;
        end else begin
            oclk_act_o = OCLK_HOLD;
        end

        if (restart) begin
            st_d.cnt = '0;
        end else if (vld_i) begin
            st_d.cnt = (st_q.cnt == term_cnt) ? '0 : st_q.cnt + CNT_W'(1);
        end
        st_d.sel = sel_i;

        if (rst) begin
            st_d.cnt = '0;
            st_d.sel = sel_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/dec_out_latch.sv
module dec_out_latch
    import dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              keep_i,
    input  logic              phase_hi_i,
    input  oclk_act_e         oclk_act_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pol_i,
    output logic [DATA_W-1:0] data_o,
    output logic [DATA_W-1:0] dac_o,
    output logic              oclk_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] dac;
        logic              oclk;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (keep_i) begin
            st_d.word = data_i;
        end

        // DAC copy follows the next held word with the present polarity
        st_d.dac = pol_i ? st_d.word : ~st_d.word;

        unique case (oclk_act_i)
            OCLK_CLEAR:  st_d.oclk = 1'b0;
            OCLK_FOLLOW: st_d.oclk = vld_i;
            OCLK_PHASE:  st_d.oclk = phase_hi_i;
            default:     st_d.oclk = st_q.oclk;
        endcase

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign data_o = st_q.word;
    assign dac_o  = st_q.dac;
    assign oclk_o = st_q.oclk;

endmodule

// File: rtl/pow2_decim_latch.sv
module pow2_decim_latch
    import dec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [SEL_W-1:0]  ratio_sel,
    input  logic              dac_pol,
    output logic [DATA_W-1:0] out_data,
    output logic              out_clk,
    output logic [DATA_W-1:0] dac_data
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic      keep;
    logic      phase_hi;
    oclk_act_e oclk_act;

    dec_phase_ctr #(
        .SEL_W (SEL_W),
        .CNT_W (CNT_W)
    ) ctr_i (
        .clk        (clk),
        .rst        (rst),
        .vld_i      (smp_vld),
        .sel_i      (ratio_sel),
        .keep_o     (keep),
        .phase_hi_o (phase_hi),
        .oclk_act_o (oclk_act)
    );

    dec_out_latch #(
        .DATA_W (DATA_W)
    ) lat_i (
        .clk        (clk),
        .rst        (rst),
        .keep_i     (keep),
        .phase_hi_i (phase_hi),
        .oclk_act_i (oclk_act),
        .vld_i      (smp_vld),
        .data_i     (smp_data),
        .pol_i      (dac_pol),
        .data_o     (out_data),
        .dac_o      (dac_data),
        .oclk_o     (out_clk)
    );

endmodule

// File: rtl/pow2_decim_latch_chk.sv
module pow2_decim_latch_chk #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_vld,
    input logic [SEL_W-1:0]  ratio_sel,
    input logic              dac_pol,
    input logic [DATA_W-1:0] out_data,
    input logic              out_clk,
    input logic [DATA_W-1:0] dac_data
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (out_data == '0) && (dac_data == '0) && !out_clk);

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(out_data));

    // R7
    sel_change_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel != $past(ratio_sel)) |=> (!out_clk && $stable(out_data)));

    // R8
    dac_pol_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dac_data == ($past(dac_pol) ? out_data : ~out_data)));

    // R6
    unit_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel == '0 && ratio_sel == $past(ratio_sel))
            |=> (out_clk == $past(smp_vld)));

    // R5
    clk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && ratio_sel != '0 && ratio_sel == $past(ratio_sel))
            |=> $stable(out_clk));

endmodule

bind pow2_decim_latch pow2_decim_latch_chk #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .ratio_sel (ratio_sel),
    .dac_pol   (dac_pol),
    .out_data  (out_data),
    .out_clk   (out_clk),
    .dac_data  (dac_data)
);

// File: tb/pow2_decim_latch_tb_top.sv
`timescale 1ns/1ps
module pow2_decim_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_data = '0;
    logic [2:0] ratio_sel = '0;
    logic       dac_pol = 1'b0;
    logic [7:0] out_data;
    logic       out_clk;
    logic [7:0] dac_data;

    always #2 clk = ~clk;   // 250 MHz

    pow2_decim_latch dut_i (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .ratio_sel (ratio_sel),
        .dac_pol   (dac_pol),
        .out_data  (out_data),
        .out_clk   (out_clk),
        .dac_data  (dac_data)
    );

    typedef struct {
        logic [7:0] data;
        logic [7:0] dac;
        logic       oclk;
        logic [2:0] sel;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Reference model state
    int         m_cnt = 0;
    logic [2:0] m_sel = '0;
    logic [7:0] m_data = '0;
    logic [7:0] m_dac = '0;
    logic       m_clk = 1'b0;
    logic [7:0] seq = 8'd3;

    task automatic step(input logic r, input logic v, input logic [2:0] s,
                        input logic [7:0] d, input logic p, input string req);
        exp_t e;
        bit   restart;
        int   term;
        int   half;
        @(negedge clk);
        rst = r; smp_vld = v; ratio_sel = s; smp_data = d; dac_pol = p;
        if (r) begin
            m_cnt = 0; m_sel = s; m_data = '0; m_dac = '0; m_clk = 1'b0;
        end else begin
            restart = (s != m_sel);
            term    = (1 << s) - 1;
            half    = (s == 0) ? 1 : (1 << (s - 1));
            if (restart)       m_clk = 1'b0;
            else if (s == 0)   m_clk = v;
            else if (v)        m_clk = (m_cnt < half);
            if (!restart && v && m_cnt == 0) m_data = d;
            m_dac = p ? m_data : ~m_data;
            if (restart)       m_cnt = 0;
            else if (v)        m_cnt = (m_cnt == term) ? 0 : m_cnt + 1;
            m_sel = s;
        end
        e.data = m_data; e.dac = m_dac; e.oclk = m_clk; e.sel = s; e.req = req;
        exp_q.push_back(e);
    endtask

    // Run n cycles; vmode: 0 always valid, 1 every other, 2 two of three
    task automatic run(input logic [2:0] s, input int n, input int vmode,
                       input logic p, input string req);
        for (int i = 0; i < n; i++) begin
            logic v;
            v = (vmode == 0) ? 1'b1 : (vmode == 1) ? (i % 2 == 0) : (i % 3 != 2);
            seq = seq + 8'd37;
            step(1'b0, v, s, seq, p, req);
        end
    endtask

    // Monitor: compares outputs one step after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (out_data !== e.data) begin
                n_fail++;
                $display("FAIL %s out_data: got %0h expected %0h", e.req, out_data, e.data);
            end
            n_cmp++;
            if (out_clk !== e.oclk) begin
                n_fail++;
                if (e.sel == 0)
                    $display("FAIL R6 out_clk: got %0b expected %0b (%s)", out_clk, e.oclk, e.req);
                else
                    $display("FAIL R5 out_clk: got %0b expected %0b (%s)", out_clk, e.oclk, e.req);
            end
            n_cmp++;
            if (dac_data !== e.dac) begin
                n_fail++;
                $display("FAIL R8 dac_data: got %0h expected %0h (%s)", dac_data, e.dac, e.req);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, with ratio 1/4 taken during reset
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 3'd2, 8'hA5, 1'b0, "R1");
        // R2: ratio 1/4 picked up during reset, no spurious restart
        run(3'd2, 12, 0, 1'b0, "R2");
        // R1: reset again mid-stream
        step(1'b1, 1'b1, 3'd0, 8'h5A, 1'b0, "R1");
        // R3: ratio 1/1, every sample passes
        run(3'd0, 20, 0, 1'b0, "R3");
        // R6: ratio 1/1 with gaps
        run(3'd0, 18, 2, 1'b0, "R6");
        // R7: change to 1/2 while streaming
        run(3'd1, 3, 0, 1'b0, "R7");
        // R2: ratio 1/2 keeps every other sample
        run(3'd1, 16, 0, 1'b0, "R2");
        // R8: polarity flips
        run(3'd1, 6, 0, 1'b1, "R8");
        run(3'd1, 4, 0, 1'b0, "R8");
        run(3'd1, 5, 2, 1'b1, "R8");
        // R7: change to 1/8 during a gap
        step(1'b0, 1'b0, 3'd3, 8'h11, 1'b0, "R7");
        // R9: ratio 1/8, valid on every other cycle
        run(3'd3, 40, 1, 1'b0, "R9");
        // R5: ratio 1/4 and 1/16 output clock phase
        run(3'd2, 30, 0, 1'b0, "R5");
        run(3'd4, 50, 2, 1'b0, "R5");
        // R4: ratio 1/32 holding between keeps
        run(3'd5, 80, 0, 1'b1, "R4");
        // R2: ratios 1/64 and 1/128
        run(3'd6, 140, 0, 1'b0, "R2");
        run(3'd7, 300, 0, 1'b0, "R2");
        // R7: back to 1/1
        run(3'd0, 4, 0, 1'b0, "R7");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 pending: got %0d expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule